// File: doc/BRIEF.md
# Multi-Core Hardware Semaphore

This block is one shared lock that several processor cores contend for. Each core has a two-bit command lane. A core can poll the lock and receives a granted or busy answer on the next cycle. It retries by polling again. A core can instead post a waiting request. That request is parked in a first-in first-out wait list, and the core is woken by a one-cycle interrupt pulse when the lock reaches it. Only the core that holds the lock may hand it back. On a legal release, ownership moves straight to the oldest waiter in the same cycle.

All contention is settled inside one clock cycle. Releases are decided first. A freed lock then goes to the head of the wait list. Only if the list is empty can a fresh request take it, and then the lowest-numbered requesting core wins. Losing pollers are told busy. Losing waiters join the list in ascending core order. The wait list has one slot for every core except the owner, so it cannot overflow.

Top module: `sem_hub`

## Requirements
- R1: At most one core owns the lock at any time, and at most one poll answer per cycle reports granted.
- R2: A poll (lane code 01) gets `resp_vld` on the next cycle. `resp_grant` is 1 if the core holds the lock after that cycle's arbitration, and 0 (busy) otherwise.
- R3: A waiting request (lane code 10) that does not get the lock at once is queued. When the lock is later given to that core, its `irq` bit is high for exactly one cycle. A waiting request that wins an idle lock at once also pulses `irq`.
- R4: Queued cores receive the lock strictly in the order their requests were queued. The list holds NUM_CORES-1 entries and never overflows.
- R5: When several cores request in the same cycle and the lock is free with an empty list, the lowest core index wins. The other pollers get busy, and the other waiters are queued in ascending index order.
- R6: A release (lane code 11) is accepted only from the current owner. A release from any other core, or while the lock is free, leaves owner and list unchanged and pulses that core's `rel_err` for one cycle.
- R7: On an accepted release with a non-empty list, the head core becomes owner on the same clock edge and its `irq` pulses.
- R8: A waiting request from a core that is already queued, or from the current owner, creates no new list entry.
- R9: Lane code 00 is idle and has no effect. Core i uses bits `req_op[2i+1:2i]`.
- R10: After synchronous reset, the lock is free, the list is empty, and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_op | input | 2*NUM_CORES | Per-core command lane: 00 idle, 01 poll, 10 wait, 11 release |
| resp_vld | output | NUM_CORES | Poll answer strobe, one cycle after the poll |
| resp_grant | output | NUM_CORES | Poll answer: 1 granted, 0 busy |
| irq | output | NUM_CORES | One-cycle wake pulse to a waiting core that received the lock |
| rel_err | output | NUM_CORES | One-cycle pulse on an illegal release |
| owner_valid | output | 1 | Lock currently held |
| owner_id | output | ID_W | Index of the holding core |

## Verification
The bench builds the block with NUM_CORES=4, which gives a wait list three entries deep. That depth lets the bench fill the list completely, with every non-owner core waiting. It also makes all same-cycle mixes of polls, waits and releases from four lanes reachable. Directed sequences cover index-order ties, duplicate waits, foreign releases and a release that hands over to the head while the head is polling. Seeded random traffic, weighted toward releases by the real owner, then exercises long handoff chains.

// File: rtl/sem_pkg.sv
package sem_pkg;
    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_POLL = 2'b01,
        OP_WAIT = 2'b10,
        OP_REL  = 2'b11
    } sem_op_e;

    function automatic int id_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/sem_wait_fifo.sv
module sem_wait_fifo #(
    parameter int NUM_CORES = 4,
    parameter int ID_W      = sem_pkg::id_bits(NUM_CORES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pop,
    input  logic [NUM_CORES-1:0] push_mask,
    output logic                 empty,
    output logic [ID_W-1:0]      head_id,
    output logic [NUM_CORES-1:0] member
);
    localparam int DEPTH = NUM_CORES - 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [ID_W-1:0]  slot_q [DEPTH];
    logic [ID_W-1:0]  slot_d [DEPTH];
    logic [CNT_W-1:0] cnt_q, cnt_d;

    assign empty   = (cnt_q == '0);
    assign head_id = slot_q[0];

    always_comb begin
        member = '0;
        for (int j = 0; j < DEPTH; j++)
            if (j < int'(cnt_q)) member[slot_q[j]] = 1'b1;
    end

    always_comb begin
        int n;
        n = int'(cnt_q);
        for (int j = 0; j < DEPTH; j++) slot_d[j] = slot_q[j];
        if (pop && n > 0) begin
            for (int j = 0; j < DEPTH - 1; j++) slot_d[j] = slot_q[j+1];
            n = n - 1;
        end
        for (int i = 0; i < NUM_CORES; i++) begin
            if (push_mask[i] && n < DEPTH) begin
                for (int j = 0; j < DEPTH; j++)
                    if (j == n) slot_d[j] = ID_W'(i);
                n = n + 1;
            end
        end
        cnt_d = CNT_W'(n);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            for (int j = 0; j < DEPTH; j++) slot_q[j] <= '0;
        end else begin
            cnt_q <= cnt_d;
            for (int j = 0; j < DEPTH; j++) slot_q[j] <= slot_d[j];
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (int'(cnt_q) - int'(pop && !empty) + $countones(push_mask)) <= DEPTH); // R4
    AST_NO_DUP: assert property (@(posedge clk) disable iff (rst)
        (push_mask & member) == '0); // R8
endmodule

// File: rtl/sem_arb.sv
module sem_arb #(
    parameter int NUM_CORES = 4,
    parameter int ID_W      = sem_pkg::id_bits(NUM_CORES)
) (
    input  logic [2*NUM_CORES-1:0] req_op,
    input  logic                   own_v,
    input  logic [ID_W-1:0]        own_id,
    input  logic                   q_empty,
    input  logic [ID_W-1:0]        q_head,
    input  logic [NUM_CORES-1:0]   q_member,
    output logic                   nxt_v,
    output logic [ID_W-1:0]        nxt_id,
    output logic                   rel_ok,
    output logic                   pop,
    output logic [NUM_CORES-1:0]   push_mask,
    output logic [NUM_CORES-1:0]   rsp_v,
    output logic [NUM_CORES-1:0]   rsp_g,
    output logic [NUM_CORES-1:0]   wake,
    output logic [NUM_CORES-1:0]   err
);
    import sem_pkg::*;

    always_comb begin
        sem_op_e op;
        rel_ok = 1'b0; pop = 1'b0; push_mask = '0;
        rsp_v = '0; rsp_g = '0; wake = '0; err = '0;
        nxt_v = own_v; nxt_id = own_id;
        // releases first
        for (int i = 0; i < NUM_CORES; i++) begin
            op = sem_op_e'(req_op[2*i +: 2]);
            if (op == OP_REL) begin
                if (own_v && own_id == ID_W'(i)) rel_ok = 1'b1;
                else                             err[i] = 1'b1;
            end
        end
        if (rel_ok) nxt_v = 1'b0;
        // waiting cores have precedence over fresh requests
        if (!nxt_v && !q_empty) begin
            nxt_v = 1'b1; nxt_id = q_head; pop = 1'b1;
            wake[q_head] = 1'b1;
        end
        // fresh requests in ascending index order
        for (int i = 0; i < NUM_CORES; i++) begin
            op = sem_op_e'(req_op[2*i +: 2]);
            if (op == OP_POLL) begin
                rsp_v[i] = 1'b1;
                if (!nxt_v) begin
                    nxt_v = 1'b1; nxt_id = ID_W'(i); rsp_g[i] = 1'b1;
                end else if (nxt_id == ID_W'(i)) begin
                    rsp_g[i] = 1'b1;
                end
            end else if (op == OP_WAIT) begin
                if (!nxt_v) begin
                    nxt_v = 1'b1; nxt_id = ID_W'(i); wake[i] = 1'b1;
                end else if (nxt_id != ID_W'(i) && !q_member[i]) begin
                    push_mask[i] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sem_hub.sv
module sem_hub #(
    parameter  int NUM_CORES = 4,
    localparam int ID_W      = sem_pkg::id_bits(NUM_CORES)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [2*NUM_CORES-1:0] req_op,
    output logic [NUM_CORES-1:0]   resp_vld,
    output logic [NUM_CORES-1:0]   resp_grant,
    output logic [NUM_CORES-1:0]   irq,
    output logic [NUM_CORES-1:0]   rel_err,
    output logic                   owner_valid,
    output logic [ID_W-1:0]        owner_id
);
    logic                 q_empty, pop, rel_ok, nxt_v;
    logic [ID_W-1:0]      q_head, nxt_id;
    logic [NUM_CORES-1:0] q_member, push_mask, rsp_v, rsp_g, wake, err;

    sem_wait_fifo #(.NUM_CORES(NUM_CORES), .ID_W(ID_W)) u_fifo (
        .clk(clk), .rst(rst), .pop(pop), .push_mask(push_mask),
        .empty(q_empty), .head_id(q_head), .member(q_member)
    );

    sem_arb #(.NUM_CORES(NUM_CORES), .ID_W(ID_W)) u_arb (
        .req_op(req_op), .own_v(owner_valid), .own_id(owner_id),
        .q_empty(q_empty), .q_head(q_head), .q_member(q_member),
        .nxt_v(nxt_v), .nxt_id(nxt_id), .rel_ok(rel_ok), .pop(pop),
        .push_mask(push_mask), .rsp_v(rsp_v), .rsp_g(rsp_g),
        .wake(wake), .err(err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            owner_valid <= 1'b0;
            owner_id    <= '0;
            resp_vld    <= '0;
            resp_grant  <= '0;
            irq         <= '0;
            rel_err     <= '0;
        end else begin
            owner_valid <= nxt_v;
            owner_id    <= nxt_id;
            resp_vld    <= rsp_v;
            resp_grant  <= rsp_g;
            irq         <= wake;
            rel_err     <= err;
        end
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(resp_grant)); // R1
    AST_GRANT_OWNER: assert property (@(posedge clk) disable iff (rst)
        (resp_grant != '0) |-> (owner_valid && resp_grant == (NUM_CORES'(1) << owner_id))); // R2
    AST_IRQ_OWNER: assert property (@(posedge clk) disable iff (rst)
        (irq != '0) |-> (owner_valid && irq == (NUM_CORES'(1) << owner_id))); // R3
    AST_HANDOFF: assert property (@(posedge clk) disable iff (rst)
        (rel_ok && !q_empty) |=> (owner_valid && owner_id == $past(q_head))); // R7
endmodule

// File: tb/sem_hub_bench.sv
module sem_hub_bench;
    localparam int N  = 4;
    localparam int IW = 2;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [2*N-1:0] req_op = '0;
    logic [N-1:0]   resp_vld, resp_grant, irq, rel_err;
    logic           owner_valid;
    logic [IW-1:0]  owner_id;

    sem_hub #(.NUM_CORES(N)) u_sem_hub (
        .clk(clk), .rst(rst), .req_op(req_op), .resp_vld(resp_vld),
        .resp_grant(resp_grant), .irq(irq), .rel_err(rel_err),
        .owner_valid(owner_valid), .owner_id(owner_id)
    );

    always #2 clk = ~clk;

    int checks = 0, failures = 0;
    // reference state
    bit   m_v = 0;
    int   m_id = 0;
    int   mq[$];
    logic [N-1:0] e_rv, e_rg, e_irq, e_err;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [2*N-1:0] op(input int core, input logic [1:0] code);
        logic [2*N-1:0] v = '0;
        v[2*core +: 2] = code;
        return v;
    endfunction

    function automatic bit queued(input int c);
        foreach (mq[k]) if (mq[k] == c) return 1;
        return 0;
    endfunction

    task automatic model(input logic [2*N-1:0] ops);
        bit rel_ok = 0;
        e_rv = '0; e_rg = '0; e_irq = '0; e_err = '0;
        for (int i = 0; i < N; i++)
            if (ops[2*i +: 2] == 2'b11) begin
                if (m_v && m_id == i) rel_ok = 1; else e_err[i] = 1'b1;
            end
        if (rel_ok) m_v = 0;
        if (!m_v && mq.size() > 0) begin
            m_id = mq.pop_front(); m_v = 1; e_irq[m_id] = 1'b1;
        end
        for (int i = 0; i < N; i++) begin
            if (ops[2*i +: 2] == 2'b01) begin
                e_rv[i] = 1'b1;
                if (!m_v) begin m_v = 1; m_id = i; e_rg[i] = 1'b1; end
                else if (m_id == i) e_rg[i] = 1'b1;
            end else if (ops[2*i +: 2] == 2'b10) begin
                if (!m_v) begin m_v = 1; m_id = i; e_irq[i] = 1'b1; end
                else if (m_id != i && !queued(i)) mq.push_back(i);
            end
        end
    endtask

    task automatic step(input logic [2*N-1:0] ops, input string tag);
        req_op = ops;
        model(ops);
        @(posedge clk); #1;
        chk({tag, "/R1"}, "owner_valid", int'(owner_valid), int'(m_v));
        if (m_v) chk({tag, "/R1"}, "owner_id", int'(owner_id), m_id);
        chk({tag, "/R2"}, "resp_vld", int'(resp_vld), int'(e_rv));
        chk({tag, "/R2"}, "resp_grant", int'(resp_grant), int'(e_rg));
        chk({tag, "/R3"}, "irq", int'(irq), int'(e_irq));
        chk({tag, "/R6"}, "rel_err", int'(rel_err), int'(e_err));
        req_op = '0;
    endtask

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        @(posedge clk); @(posedge clk); #1;
        rst = 1'b0;
        // R10 reset state
        chk("R10", "owner_valid", int'(owner_valid), 0);
        chk("R10", "resp_vld", int'(resp_vld), 0);
        chk("R10", "irq", int'(irq), 0);
        chk("R10", "rel_err", int'(rel_err), 0);
        step('0, "R9 idle");
        // R5: polls from 1 and 2 and a wait from 3 in one cycle
        step(op(1, 2'b01) | op(2, 2'b01) | op(3, 2'b10), "R5 tie");
        step(op(0, 2'b10) | op(2, 2'b10), "R5 enqueue order");
        // R8: duplicate wait and owner wait
        step(op(3, 2'b10), "R8 dup wait");
        step(op(1, 2'b10), "R8 owner wait");
        step(op(0, 2'b01), "R2 busy poll");
        // R6: foreign release
        step(op(2, 2'b11), "R6 foreign release");
        // R7 handoff to head 3, then 3 releases while head 0 polls
        step(op(1, 2'b11), "R7 handoff");
        step(op(3, 2'b11) | op(0, 2'b01), "R7 handoff with poll");
        step(op(0, 2'b11), "R4 fifo order");
        step(op(2, 2'b11), "R4 drain");
        step(op(1, 2'b11), "R6 release when free");
        step(op(3, 2'b01), "R2 poll idle");
        // R4: fill list with all three non-owners
        step(op(0, 2'b10) | op(1, 2'b10) | op(2, 2'b10), "R4 full");
        step(op(3, 2'b11), "R4 full handoff");
        step(op(0, 2'b11) | op(1, 2'b11), "R6 mixed release");
        step(op(1, 2'b11), "R4 handoff");
        step(op(2, 2'b11), "R3 last");
        // seeded random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [2*N-1:0] ops = '0;
            for (int c = 0; c < N; c++) begin
                int r = int'($urandom % 8);
                if (r == 4) ops[2*c +: 2] = 2'b01;
                else if (r == 5) ops[2*c +: 2] = 2'b10;
                else if (r == 6) ops[2*c +: 2] = 2'b11;
                else if (r == 7 && m_v && m_id == c) ops[2*c +: 2] = 2'b11;
            end
            step(ops, "R5 random");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule